// File: doc/BRIEF.md
# Register Window Controller

This block tracks the bookkeeping of a windowed integer register file. It holds the current window pointer and the pair of counters that say how many windows may still be entered by a save and how many may be left by a restore. Each cycle it may accept one command: save, restore, return or flush-windows. For that command it decides the new pointer and counter values. It also decides whether the command completes or raises a trap. One cycle later it reports the result: a trap type, a three-bit trap sub-index and, on success, a write-back of the address sum that the datapath computed for the command.

The clean-window count, the other-window count and the six-bit window-state field are held by privileged registers outside this block and arrive as inputs. The register storage itself, trap vectoring and address arithmetic stay outside. The block only passes the externally computed sum through.

A spill or fill trap still moves the pointer. A save that spills moves it forward by two windows, so the trap handler lands in the window it has to empty.

Top module: `rwin_ctrl`

## Requirements
- R1: After reset the pointer is 0, the save counter is NWIN-2, the restore counter is 0, no response is valid and the trap output is none (code 0).
- R2: A save with a nonzero save counter and a clean-window count different from the restore counter moves the pointer forward by one (modulo NWIN). It decrements the save counter, increments the restore counter and writes back the sum.
- R3: A save with a zero save counter raises a spill trap (normal code 1, other code 2). The pointer moves forward by two modulo NWIN, the counters are unchanged and nothing is written back.
- R4: A save with a nonzero save counter whose clean-window count minus restore counter is zero (modulo 2^CW) raises the clean-window trap (code 5). The pointer moves forward by one and the counters are unchanged.
- R5: A restore, or an aligned return, always moves the pointer back by one modulo NWIN. With a zero restore counter it raises a fill trap (normal code 3, other code 4) and leaves the counters unchanged. Otherwise it increments the save counter, decrements the restore counter and writes back the sum.
- R6: Spill and fill traps use the other variant with sub-index window-state bits [5:3] when the other-window count is nonzero. Otherwise they use the normal variant with sub-index bits [2:0]. Every other response carries sub-index 0.
- R7: A return whose sum has bit 1 or bit 0 set raises the misaligned trap (code 6). It changes neither the pointer nor the counters and writes nothing back.
- R8: Flush-windows raises a spill trap when the save counter equals NWIN-2 and no trap otherwise. It never changes the pointer or the counters.
- R9: Each accepted command gives exactly one valid response on the following cycle. A cycle with no command gives no response on the following cycle and leaves all state unchanged.
- R10: The save counter plus the restore counter always equals NWIN-2.

Command codes: save 0, restore 1, return 2, flush 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | A command is presented this cycle |
| cmd_op | input | 2 | Command code (save 0, restore 1, return 2, flush 3) |
| cmd_sum | input | DW | Address sum from the datapath; low two bits checked on return |
| cleanwin | input | CW | Clean-window count from privileged state |
| otherwin | input | CW | Other-window count from privileged state |
| wstate | input | 6 | Window-state field giving the trap sub-indices |
| rsp_valid | output | 1 | A response is present |
| rsp_trap | output | 3 | Trap code, 0 when none |
| rsp_sub | output | 3 | Trap sub-index |
| wb_en | output | 1 | Write back the sum |
| wb_data | output | DW | Sum to write back |
| cwp | output | CW | Current window pointer |
| cansave | output | CW | Windows that may still be saved into |
| canrestore | output | CW | Windows that may still be restored from |

## Verification
The bench builds the block with six windows. With that count the modulo wrap is not a power of two, so both the forward-by-two step from windows 4 and 5 and the backward step from 0 to 5 wrap through a real subtraction, not bit truncation. The reset save counter of 4 lets the bench reach the spill boundary in four saves, and the fill boundary soon after. The clean-window, other-window and window-state inputs are driven freely, which reaches both trap variants and the clean-window trap at any restore depth.

// File: rtl/rwin_pkg.sv
package rwin_pkg;
  typedef enum logic [1:0] {
    OP_SAVE    = 2'd0,
    OP_RESTORE = 2'd1,
    OP_RETURN  = 2'd2,
    OP_FLUSH   = 2'd3
  } rwin_op_e;

  typedef enum logic [2:0] {
    TRAP_NONE      = 3'd0,
    TRAP_SPILL_NRM = 3'd1,
    TRAP_SPILL_OTH = 3'd2,
    TRAP_FILL_NRM  = 3'd3,
    TRAP_FILL_OTH  = 3'd4,
    TRAP_CLEAN     = 3'd5,
    TRAP_MISALIGN  = 3'd6
  } rwin_trap_e;

  typedef enum logic [1:0] {
    STEP_HOLD  = 2'd0,
    STEP_FWD1  = 2'd1,
    STEP_FWD2  = 2'd2,
    STEP_BACK1 = 2'd3
  } ptr_step_e;

  typedef enum logic [1:0] {
    MOVE_HOLD = 2'd0,
    MOVE_PUSH = 2'd1,
    MOVE_POP  = 2'd2
  } cnt_move_e;
endpackage

// File: rtl/rwin_decide.sv
module rwin_decide
  import rwin_pkg::*;
#(
  parameter int NWIN = 8,
  parameter int CW   = $clog2(NWIN)
) (
  input  logic          cmd_valid,
  input  logic [1:0]    cmd_op,
  input  logic [1:0]    sum_lo,
  input  logic [CW-1:0] cansave,
  input  logic [CW-1:0] canrestore,
  input  logic [CW-1:0] cleanwin,
  input  logic [CW-1:0] otherwin,
  input  logic [5:0]    wstate,
  output rwin_trap_e    trap,
  output logic [2:0]    sub,
  output ptr_step_e     step,
  output cnt_move_e     move,
  output logic          wb
);
  localparam logic [CW-1:0] FULL_SAVE = CW'(NWIN - 2);

  // named internal events, visible to assertions
  logic          use_other;
  logic          save_empty;
  logic          rest_empty;
  logic          misaligned;
  logic [CW-1:0] clean_gap;
  rwin_trap_e    spill_kind;
  rwin_trap_e    fill_kind;
  logic [2:0]    vec_sel;

  assign use_other  = |otherwin;
  assign save_empty = (cansave == '0);
  assign rest_empty = (canrestore == '0);
  assign misaligned = |sum_lo;
  assign clean_gap  = cleanwin - canrestore;
  assign spill_kind = use_other ? TRAP_SPILL_OTH : TRAP_SPILL_NRM;
  assign fill_kind  = use_other ? TRAP_FILL_OTH : TRAP_FILL_NRM;
  assign vec_sel    = use_other ? wstate[5:3] : wstate[2:0];

  always_comb begin
    trap = TRAP_NONE;
    sub  = 3'd0;
    step = STEP_HOLD;
    move = MOVE_HOLD;
    wb   = 1'b0;
    if (cmd_valid) begin
      unique case (rwin_op_e'(cmd_op))
        OP_SAVE: begin
          if (save_empty) begin
            trap = spill_kind;
            sub  = vec_sel;
            step = STEP_FWD2;
          end else if (clean_gap == '0) begin
            trap = TRAP_CLEAN;
            step = STEP_FWD1;
          end else begin
            step = STEP_FWD1;
            move = MOVE_PUSH;
            wb   = 1'b1;
          end
        end
        OP_RESTORE, OP_RETURN: begin
          if (rwin_op_e'(cmd_op) == OP_RETURN && misaligned) begin
            trap = TRAP_MISALIGN;
          end else begin
            step = STEP_BACK1;
            if (rest_empty) begin
              trap = fill_kind;
              sub  = vec_sel;
            end else begin
              move = MOVE_POP;
              wb   = 1'b1;
            end
          end
        end
        OP_FLUSH: begin
          if (cansave == FULL_SAVE) begin
            trap = spill_kind;
            sub  = vec_sel;
          end
        end
        default: ;
      endcase
    end
  end

  // R6: the sub-index is only nonzero alongside a spill or fill trap
  always_comb begin
    if (sub != 3'd0)
      p_sub_only_trap_r6: assert (trap == TRAP_SPILL_NRM || trap == TRAP_SPILL_OTH ||
                                  trap == TRAP_FILL_NRM || trap == TRAP_FILL_OTH);
  end
endmodule

// File: rtl/rwin_ptr.sv
module rwin_ptr
  import rwin_pkg::*;
#(
  parameter int NWIN = 8,
  parameter int CW   = $clog2(NWIN)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  ptr_step_e     step,
  output logic [CW-1:0] cwp
);
  function automatic logic [CW-1:0] ptr_fwd(input logic [CW-1:0] p, input int unsigned amt);
    int unsigned s;
    s = 32'(p) + amt;
    if (s >= NWIN) s = s - NWIN;
    return CW'(s);
  endfunction

  function automatic logic [CW-1:0] ptr_back(input logic [CW-1:0] p);
    if (p == '0) return CW'(NWIN - 1);
    return p - 1'b1;
  endfunction

  logic [CW-1:0] cwp_next;

  always_comb begin
    unique case (step)
      STEP_FWD1:  cwp_next = ptr_fwd(cwp, 1);
      STEP_FWD2:  cwp_next = ptr_fwd(cwp, 2);
      STEP_BACK1: cwp_next = ptr_back(cwp);
      default:    cwp_next = cwp;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cwp <= '0;
    else        cwp <= cwp_next;
  end

  // R2: the pointer never leaves the range of existing windows
  p_ptr_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
    32'(cwp) < NWIN);
endmodule

// File: rtl/rwin_count.sv
module rwin_count
  import rwin_pkg::*;
#(
  parameter int NWIN = 8,
  parameter int CW   = $clog2(NWIN)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  cnt_move_e     move,
  output logic [CW-1:0] cansave,
  output logic [CW-1:0] canrestore
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cansave    <= CW'(NWIN - 2);
      canrestore <= '0;
    end else begin
      unique case (move)
        MOVE_PUSH: begin
          cansave    <= cansave - 1'b1;
          canrestore <= canrestore + 1'b1;
        end
        MOVE_POP: begin
          cansave    <= cansave + 1'b1;
          canrestore <= canrestore - 1'b1;
        end
        default: ;
      endcase
    end
  end

  // R10: the two counters always account for NWIN-2 windows together
  p_conserve_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (32'(cansave) + 32'(canrestore)) == NWIN - 2);
endmodule

// File: rtl/rwin_ctrl.sv
module rwin_ctrl
  import rwin_pkg::*;
#(
  parameter int NWIN = 8,
  parameter int DW   = 32,
  localparam int CW  = $clog2(NWIN)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_valid,
  input  logic [1:0]    cmd_op,
  input  logic [DW-1:0] cmd_sum,
  input  logic [CW-1:0] cleanwin,
  input  logic [CW-1:0] otherwin,
  input  logic [5:0]    wstate,
  output logic          rsp_valid,
  output logic [2:0]    rsp_trap,
  output logic [2:0]    rsp_sub,
  output logic          wb_en,
  output logic [DW-1:0] wb_data,
  output logic [CW-1:0] cwp,
  output logic [CW-1:0] cansave,
  output logic [CW-1:0] canrestore
);
  rwin_trap_e dec_trap;
  logic [2:0] dec_sub;
  ptr_step_e  dec_step;
  cnt_move_e  dec_move;
  logic       dec_wb;

  rwin_decide #(.NWIN(NWIN), .CW(CW)) u_decide (
    .cmd_valid (cmd_valid),
    .cmd_op    (cmd_op),
    .sum_lo    (cmd_sum[1:0]),
    .cansave   (cansave),
    .canrestore(canrestore),
    .cleanwin  (cleanwin),
    .otherwin  (otherwin),
    .wstate    (wstate),
    .trap      (dec_trap),
    .sub       (dec_sub),
    .step      (dec_step),
    .move      (dec_move),
    .wb        (dec_wb)
  );

  rwin_ptr #(.NWIN(NWIN), .CW(CW)) u_ptr (
    .clk  (clk),
    .rst_n(rst_n),
    .step (dec_step),
    .cwp  (cwp)
  );

  rwin_count #(.NWIN(NWIN), .CW(CW)) u_count (
    .clk       (clk),
    .rst_n     (rst_n),
    .move      (dec_move),
    .cansave   (cansave),
    .canrestore(canrestore)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_trap  <= TRAP_NONE;
      rsp_sub   <= 3'd0;
      wb_en     <= 1'b0;
      wb_data   <= '0;
    end else begin
      rsp_valid <= cmd_valid;
      rsp_trap  <= dec_trap;
      rsp_sub   <= dec_sub;
      wb_en     <= dec_wb;
      if (dec_wb) wb_data <= cmd_sum;
    end
  end

  // R3: a save with nothing left to save spills and keeps both counters
  p_spill_keeps_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_op == 2'd0 && cansave == '0) |=>
      ((rsp_trap == TRAP_SPILL_NRM || rsp_trap == TRAP_SPILL_OTH) &&
       cansave == $past(cansave) && canrestore == $past(canrestore) && !wb_en));

  // R5: an empty restore counter on restore gives a fill trap
  p_fill_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_op == 2'd1 && canrestore == '0) |=>
      ((rsp_trap == TRAP_FILL_NRM || rsp_trap == TRAP_FILL_OTH) && !wb_en &&
       cwp != $past(cwp)));

  // R7: a misaligned return touches no window state
  p_misalign_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_op == 2'd2 && cmd_sum[1:0] != 2'b00) |=>
      (rsp_trap == TRAP_MISALIGN && !wb_en && $stable(cwp) &&
       $stable(cansave) && $stable(canrestore)));

  // R8: flush never changes the window state
  p_flush_static_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_op == 2'd3) |=>
      ($stable(cwp) && $stable(cansave) && !wb_en));

  // R9: idle cycles produce no response and no state change
  p_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_valid |=> (!rsp_valid && !wb_en && rsp_trap == TRAP_NONE &&
                    $stable(cwp) && $stable(cansave)));

  // R9: every command is answered on the next cycle
  p_answer_r9: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |=> rsp_valid);

  // R6: other-window selects the upper window-state field for a spill
  p_other_sub_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_op == 2'd0 && cansave == '0 && otherwin != '0) |=>
      (rsp_trap == TRAP_SPILL_OTH && rsp_sub == $past(wstate[5:3])));
endmodule

// File: tb/tb_rwin_ctrl.sv
module tb_rwin_ctrl;
  localparam int NW = 6;
  localparam int DW = 32;
  localparam int CW = $clog2(NW);

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cmd_valid = 1'b0;
  logic [1:0]    cmd_op = '0;
  logic [DW-1:0] cmd_sum = '0;
  logic [CW-1:0] cleanwin = '0;
  logic [CW-1:0] otherwin = '0;
  logic [5:0]    wstate = '0;
  logic          rsp_valid;
  logic [2:0]    rsp_trap;
  logic [2:0]    rsp_sub;
  logic          wb_en;
  logic [DW-1:0] wb_data;
  logic [CW-1:0] cwp;
  logic [CW-1:0] cansave;
  logic [CW-1:0] canrestore;

  rwin_ctrl #(.NWIN(NW), .DW(DW)) dut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_sum(cmd_sum), .cleanwin(cleanwin), .otherwin(otherwin), .wstate(wstate),
    .rsp_valid(rsp_valid), .rsp_trap(rsp_trap), .rsp_sub(rsp_sub),
    .wb_en(wb_en), .wb_data(wb_data), .cwp(cwp), .cansave(cansave),
    .canrestore(canrestore)
  );

  always #2.5 clk = ~clk;

  int n_cmp = 0;
  int n_bad = 0;
  int m_cwp, m_cs, m_cr;

  task automatic cmp(input string req, input string what, input longint act, input longint exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  // drive at a falling edge, predict, let one rising edge pass, compare at the next falling edge
  task automatic run_cmd(input bit v, input int op, input logic [DW-1:0] sum,
                         input int clean, input int oth, input int ws);
    int e_trap, e_sub, e_wb, vec, spill, fill;
    string tag;
    cmd_valid = v; cmd_op = 2'(op); cmd_sum = sum;
    cleanwin = CW'(clean); otherwin = CW'(oth); wstate = 6'(ws);
    e_trap = 0; e_sub = 0; e_wb = 0;
    spill = (oth != 0) ? 2 : 1;
    fill  = (oth != 0) ? 4 : 3;
    vec   = (oth != 0) ? ((ws >> 3) & 7) : (ws & 7);
    tag = "R9";
    if (v) begin
      case (op)
        0: begin
          if (m_cs == 0) begin
            e_trap = spill; e_sub = vec; m_cwp = (m_cwp + 2) % NW;
            tag = (oth != 0) ? "R6" : "R3";
          end else if (((clean - m_cr) & ((1 << CW) - 1)) == 0) begin
            e_trap = 5; m_cwp = (m_cwp + 1) % NW; tag = "R4";
          end else begin
            e_wb = 1; m_cwp = (m_cwp + 1) % NW; m_cs--; m_cr++; tag = "R2";
          end
        end
        1, 2: begin
          if (op == 2 && (sum & 3) != 0) begin
            e_trap = 6; tag = "R7";
          end else begin
            m_cwp = (m_cwp + NW - 1) % NW;
            if (m_cr == 0) begin
              e_trap = fill; e_sub = vec; tag = (oth != 0) ? "R6" : "R5";
            end else begin
              e_wb = 1; m_cs++; m_cr--; tag = "R5";
            end
          end
        end
        default: begin
          tag = "R8";
          if (m_cs == NW - 2) begin e_trap = spill; e_sub = vec; end
        end
      endcase
    end
    @(posedge clk);
    @(negedge clk);
    cmp(tag, "rsp_valid", rsp_valid, v);
    cmp(tag, "rsp_trap", rsp_trap, e_trap);
    cmp(tag, "rsp_sub", rsp_sub, e_sub);
    cmp(tag, "wb_en", wb_en, e_wb);
    if (e_wb != 0) cmp(tag, "wb_data", wb_data, sum);
    cmp(tag, "cwp", cwp, m_cwp);
    cmp(tag, "cansave", cansave, m_cs);
    cmp(tag, "canrestore", canrestore, m_cr);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    m_cwp = 0; m_cs = NW - 2; m_cr = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    cmp("R1", "cwp", cwp, 0);
    cmp("R1", "cansave", cansave, NW - 2);
    cmp("R1", "canrestore", canrestore, 0);
    cmp("R1", "rsp_valid", rsp_valid, 0);
    cmp("R1", "rsp_trap", rsp_trap, 0);
    // R9 idle
    run_cmd(0, 0, 32'h10, 7, 0, 0);
    // R8 flush at full save count -> spill
    run_cmd(1, 3, 0, 7, 0, 6'b101_011);
    // R5 restore with empty restore counter -> fill, pointer wraps 0 -> 5
    run_cmd(1, 1, 0, 7, 0, 6'b101_011);
    // R2 successful saves until the save counter is exhausted
    for (int i = 0; i < NW - 2; i++) run_cmd(1, 0, 32'h1000 + i * 4, 7, 0, 0);
    // R3 spill normal, then R6 spill other, forward two with wrap
    run_cmd(1, 0, 0, 7, 0, 6'b101_011);
    run_cmd(1, 0, 0, 7, 1, 6'b101_011);
    // R8 flush with empty save counter -> no trap
    run_cmd(1, 3, 0, 7, 0, 0);
    // R7 misaligned returns
    run_cmd(1, 2, 32'h2001, 7, 0, 0);
    run_cmd(1, 2, 32'h2002, 7, 0, 0);
    // R5 aligned return and restore
    run_cmd(1, 2, 32'h3000, 7, 0, 0);
    run_cmd(1, 1, 32'h3004, 7, 0, 0);
    // R4 clean-window trap: cleanwin equals restore counter
    run_cmd(1, 0, 32'h4000, m_cr, 0, 0);
    // mixed traffic
    for (int i = 0; i < 3000; i++) begin
      bit v;
      int op;
      logic [DW-1:0] s;
      v  = ($urandom % 8) != 0;
      op = $urandom % 4;
      s  = $urandom;
      if (($urandom % 2) == 0) s[1:0] = 2'b00;
      run_cmd(v, op, s, $urandom % 8, (($urandom % 3) == 0) ? 1 : 0, $urandom % 64);
    end
    // R10 conservation at the ports
    cmp("R10", "cansave+canrestore", 32'(cansave) + 32'(canrestore), NW - 2);
    summary();
    $finish;
  end
endmodule